// File: doc/BRIEF.md
# Command Buffer Packet Decoder

This block sits at the front of a command processor. It takes a stream of 64-bit words from a command buffer and splits them into packets. Each packet is one header word followed by a number of payload words, and that number is given by the header. The decoder checks each header and pulls out its opcode, its payload length and its 32-bit inline field. It collects the payload words into a record and then does one of three things: it passes the record to an executor, it runs the command itself, or it signals the end of the buffer.

Register writes are handled inside the block. They go to a local register file, and the executor reads that file through a dedicated read port. Every other valid command is offered to the executor on a valid/ready record. The decoder then stalls the word stream until the executor pulses done, so commands complete strictly in buffer order, including long kernel launches. A malformed header raises a one-cycle error pulse. The payload words that its count field implies are then consumed and thrown away, so decoding picks up again at the next header.

Top module: `cbpd_decoder`

## Requirements
- R1: After reset, word_ready_o is 1, cmd_valid_o, err_o and finish_o are 0, and every register file entry reads as 0.
- R2: A header has reserved bits [7:0] that must be zero, an opcode in [15:8], a count in [29:16] equal to twice the number of payload words, a tag in [31:30] that must be 3, and an inline field in [63:32]. A well-formed header with opcode 3 to 9 produces cmd_valid_o in the cycle after its last word is accepted, or after the header itself when the count is zero. The record carries the opcode, the inline field, the word count, and payload word k in slot k (bits 64k+63:64k).
- R3: A header whose tag is not 3, whose reserved bits are not zero, whose count is odd, or whose opcode is 0 or above 9 sets err_o high for the one cycle after the header is accepted. The next count>>1 words are then accepted and discarded, no command is issued for them, and decoding resumes with the word after them.
- R4: A count above 16, meaning more than 8 payload words, is treated as a malformed header, exactly as in R3.
- R5: An opcode 8 header is malformed as in R3 unless its number of payload words equals 1 plus inline bits [10:8].
- R6: Opcode 2 stores its first payload word into register file entry `inline`, provided `inline` is below 40. The entry can be read on rf_rdata_o through rf_raddr_i. An index of 40 or more changes no entry. No record is offered to the executor.
- R7: Opcode 1 pulses finish_o for exactly one cycle, in the cycle after its last word is accepted, and offers no record.
- R8: While cmd_valid_o is high and cmd_ready_i is low, the record is held unchanged. Once the record has been accepted, no word is taken until cmd_done_i is seen.
- R9: word_ready_o is low whenever cmd_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 64 | Command buffer word |
| word_valid_i | input | 1 | word_i is valid |
| word_ready_o | output | 1 | Decoder accepts a word this cycle |
| cmd_valid_o | output | 1 | Decoded record offered to executor |
| cmd_ready_i | input | 1 | Executor takes the record |
| cmd_done_i | input | 1 | Executor finished the accepted command |
| cmd_opcode_o | output | 8 | Record opcode |
| cmd_inline_o | output | 32 | Record inline field |
| cmd_nwords_o | output | 4 | Number of valid payload slots |
| cmd_payload_o | output | 512 | Payload slots, slot k at bits 64k+63:64k |
| finish_o | output | 1 | One-cycle end-of-buffer pulse |
| err_o | output | 1 | One-cycle malformed-header pulse |
| rf_raddr_i | input | 6 | Register file read index |
| rf_rdata_o | output | 64 | Register file read data, zero when the index is out of range |

## Verification
Random packets mix executor commands with 0 to 8 payload words, well-formed opcode 8 launches, finishes, register writes with in-range and out-of-range indices, and each kind of malformed header. The payload of a skipped packet is random data that often looks like a valid header, so a skip-length error shows up as a wrong command or a spurious error on a later packet. Directed cases place the word count right at the limit and one past it, use opcode 0 and 10, send back-to-back zero-count errors, and write index 45. The last case tells a dropped write apart from one that aliases onto a low entry. Random executor delays on ready and done check both that the record is held and that the word stream stalls.

// File: rtl/cbpd_pkg.sv
package cbpd_pkg;
  localparam logic [7:0] OP_FINISH = 8'd1;
  localparam logic [7:0] OP_WREG   = 8'd2;
  localparam logic [7:0] OP_LAUNCH = 8'd8;
  localparam logic [7:0] OP_LAST   = 8'd9;

  typedef struct packed {
    logic [7:0]  opcode;
    logic [31:0] inl;
    logic [12:0] nwords;
    logic        bad;
  } hdr_t;
endpackage

// File: rtl/cbpd_hdr_chk.sv
module cbpd_hdr_chk
  import cbpd_pkg::*;
#(
  parameter int MAX_WORDS = 8
) (
  input  logic [63:0] word_i,
  output hdr_t        hdr_o
);
  logic [13:0] cnt;
  logic        bad_op, bad_len, bad_args;

  assign cnt      = word_i[29:16];
  assign bad_op   = (word_i[15:8] == 8'd0) || (word_i[15:8] > OP_LAST);
  assign bad_len  = cnt[0] || (cnt[13:1] > 13'(MAX_WORDS));
  assign bad_args = (word_i[15:8] == OP_LAUNCH) &&
                    (cnt[13:1] != 13'(word_i[42:40]) + 13'd1);

  always_comb begin
    hdr_o.opcode = word_i[15:8];
    hdr_o.inl    = word_i[63:32];
    hdr_o.nwords = cnt[13:1];
    hdr_o.bad    = (word_i[31:30] != 2'b11) || (word_i[7:0] != 8'd0) ||
                   bad_op || bad_len || bad_args;
  end
endmodule

// File: rtl/cbpd_regfile.sv
module cbpd_regfile #(
  parameter int NUM_REGS = 40,
  localparam int RIDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [31:0]       waddr_i,
  input  logic [63:0]       wdata_i,
  input  logic [RIDX_W-1:0] raddr_i,
  output logic [63:0]       rdata_o
);
  logic [63:0] mem_q [NUM_REGS];
  logic        w_in_range, r_in_range;

  assign w_in_range = waddr_i < 32'(NUM_REGS);
  assign r_in_range = {1'b0, raddr_i} < (RIDX_W+1)'(NUM_REGS);
  assign rdata_o    = r_in_range ? mem_q[raddr_i] : 64'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= 64'd0;
    end else if (we_i && w_in_range) begin
      mem_q[waddr_i[RIDX_W-1:0]] <= wdata_i;
    end
  end

  // R6: an in-range write is visible on the read port next cycle
  a_r6_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && w_in_range && (waddr_i == 32'(raddr_i))) |=>
    ((raddr_i != $past(raddr_i)) || (rdata_o == $past(wdata_i))));
endmodule

// File: rtl/cbpd_decoder.sv
module cbpd_decoder
  import cbpd_pkg::*;
#(
  parameter int MAX_WORDS = 8,
  parameter int NUM_REGS  = 40,
  localparam int CNT_W  = $clog2(MAX_WORDS + 1),
  localparam int RIDX_W = $clog2(NUM_REGS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [63:0]            word_i,
  input  logic                   word_valid_i,
  output logic                   word_ready_o,
  output logic                   cmd_valid_o,
  input  logic                   cmd_ready_i,
  input  logic                   cmd_done_i,
  output logic [7:0]             cmd_opcode_o,
  output logic [31:0]            cmd_inline_o,
  output logic [CNT_W-1:0]       cmd_nwords_o,
  output logic [MAX_WORDS*64-1:0] cmd_payload_o,
  output logic                   finish_o,
  output logic                   err_o,
  input  logic [RIDX_W-1:0]      rf_raddr_i,
  output logic [63:0]            rf_rdata_o
);
  localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

  typedef enum logic [2:0] {ST_HDR, ST_PAY, ST_SKIP, ST_EXEC, ST_WAIT} st_e;

  st_e              state_q, state_d;
  logic [7:0]       op_q, op_d;
  logic [31:0]      inl_q, inl_d;
  logic [CNT_W-1:0] nw_q, nw_d, idx_q, idx_d;
  logic [12:0]      left_q, left_d;
  logic             err_q, err_d;
  logic [63:0]      pay_q [MAX_WORDS];
  logic             acc, local_op, rf_we;
  hdr_t             hdr;

  cbpd_hdr_chk #(.MAX_WORDS(MAX_WORDS)) u_hdr (.word_i(word_i), .hdr_o(hdr));

  assign word_ready_o = (state_q == ST_HDR) || (state_q == ST_PAY) || (state_q == ST_SKIP);
  assign acc          = word_valid_i && word_ready_o;
  assign local_op     = (op_q == OP_FINISH) || (op_q == OP_WREG);
  assign cmd_valid_o  = (state_q == ST_EXEC) && !local_op;
  assign finish_o     = (state_q == ST_EXEC) && (op_q == OP_FINISH);
  assign rf_we        = (state_q == ST_EXEC) && (op_q == OP_WREG) && (nw_q != '0);
  assign err_o        = err_q;
  assign cmd_opcode_o = op_q;
  assign cmd_inline_o = inl_q;
  assign cmd_nwords_o = nw_q;

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_pay
    assign cmd_payload_o[g*64 +: 64] = pay_q[g];
  end

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    inl_d   = inl_q;
    nw_d    = nw_q;
    idx_d   = idx_q;
    left_d  = left_q;
    err_d   = 1'b0;
    unique case (state_q)
      ST_HDR: if (acc) begin
        if (hdr.bad) begin
          err_d   = 1'b1;
          left_d  = hdr.nwords;
          state_d = (hdr.nwords != 13'd0) ? ST_SKIP : ST_HDR;
        end else begin
          op_d    = hdr.opcode;
          inl_d   = hdr.inl;
          nw_d    = CNT_W'(hdr.nwords);
          idx_d   = '0;
          state_d = (hdr.nwords != 13'd0) ? ST_PAY : ST_EXEC;
        end
      end
      ST_PAY: if (acc) begin
        idx_d = idx_q + 1'b1;
        if (idx_d == nw_q) state_d = ST_EXEC;
      end
      ST_SKIP: if (acc) begin
        left_d = left_q - 13'd1;
        if (left_q == 13'd1) state_d = ST_HDR;
      end
      ST_EXEC: begin
        if (local_op)         state_d = ST_HDR;
        else if (cmd_ready_i) state_d = ST_WAIT;
      end
      ST_WAIT: if (cmd_done_i) state_d = ST_HDR;
      default: state_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      op_q    <= '0;
      inl_q   <= '0;
      nw_q    <= '0;
      idx_q   <= '0;
      left_q  <= '0;
      err_q   <= 1'b0;
      for (int i = 0; i < MAX_WORDS; i++) pay_q[i] <= 64'd0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      inl_q   <= inl_d;
      nw_q    <= nw_d;
      idx_q   <= idx_d;
      left_q  <= left_d;
      err_q   <= err_d;
      if (state_q == ST_PAY && acc) pay_q[idx_q[IDX_W-1:0]] <= word_i;
    end
  end

  cbpd_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(rf_we), .waddr_i(inl_q),
    .wdata_i(pay_q[0]), .raddr_i(rf_raddr_i), .rdata_o(rf_rdata_o));

  a_r8_hold_record: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
    (cmd_valid_o && $stable(cmd_opcode_o) && $stable(cmd_inline_o) && $stable(cmd_payload_o)));
  a_r8_stall_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_ready_i) |=> !word_ready_o);
  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && word_ready_o));
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> !finish_o);
  a_r3_err_no_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !cmd_valid_o);
  a_r4_word_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_nwords_o <= CNT_W'(MAX_WORDS)));
endmodule

// File: tb/test_cbpd_decoder.sv
`timescale 1ns/1ps
module test_cbpd_decoder;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic [63:0]  word = '0;
  logic         word_valid = 1'b0, word_ready;
  logic         cmd_valid, cmd_ready = 1'b0, cmd_done = 1'b0;
  logic [7:0]   cmd_opcode;
  logic [31:0]  cmd_inline;
  logic [3:0]   cmd_nwords;
  logic [511:0] cmd_payload;
  logic         finish, err;
  logic [5:0]   rf_raddr = '0;
  logic [63:0]  rf_rdata;

  int n_chk = 0, n_fail = 0;
  logic [63:0] pw [8];
  logic [63:0] exp_rf [40];

  always #2.5 clk = ~clk;

  cbpd_decoder i_cbpd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .word_valid_i(word_valid),
    .word_ready_o(word_ready), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_done_i(cmd_done), .cmd_opcode_o(cmd_opcode), .cmd_inline_o(cmd_inline),
    .cmd_nwords_o(cmd_nwords), .cmd_payload_o(cmd_payload), .finish_o(finish),
    .err_o(err), .rf_raddr_i(rf_raddr), .rf_rdata_o(rf_rdata));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] op, input logic [13:0] cnt,
                                     input logic [31:0] inl, input logic [1:0] tag,
                                     input logic [7:0] rsv);
    return {inl, tag, cnt, op, rsv};
  endfunction

  function automatic bit is_bad(input logic [63:0] h);
    int n = int'(h[29:17]);
    if (h[31:30] != 2'b11 || h[7:0] != 0) return 1;                // R3
    if (h[16] || h[15:8] == 0 || h[15:8] > 9) return 1;             // R3
    if (n > 8) return 1;                                            // R4
    if (h[15:8] == 8 && n != int'(h[42:40]) + 1) return 1;          // R5
    return 0;
  endfunction

  task automatic push(input logic [63:0] w);
    if ($urandom % 4 == 0) @(negedge clk);
    @(negedge clk);
    while (!word_ready) @(negedge clk);
    word = w; word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic read_chk(input int idx, input string req);
    logic [63:0] e;
    e = (idx < 40) ? exp_rf[idx] : 64'd0;
    rf_raddr = 6'(idx);
    #0.5;
    chk(rf_rdata == e, req, rf_rdata, e);
  endtask

  task automatic run_pkt(input logic [63:0] h);
    int n = int'(h[29:17]);
    logic [7:0] op = h[15:8];
    for (int i = 0; i < 8; i++) pw[i] = {$urandom, $urandom};
    push(h);
    if (is_bad(h)) begin
      chk(err == 1'b1, "R3/R4/R5 err pulse", 64'(err), 1);
      for (int i = 0; i < n; i++) begin
        push(pw[i]);
        chk(err == 1'b0 && cmd_valid == 1'b0, "R3 skipped word", 64'({err, cmd_valid}), 0);
      end
      return;
    end
    chk(err == 1'b0 || n > 0, "R3 no err on good header", 64'(err), 0);
    for (int i = 0; i < n; i++) push(pw[i]);
    if (op == 8'd1) begin
      chk(finish == 1'b1 && cmd_valid == 1'b0, "R7 finish pulse", 64'({finish, cmd_valid}), 2);
      @(negedge clk);
      chk(finish == 1'b0, "R7 finish one cycle", 64'(finish), 0);
    end else if (op == 8'd2) begin
      chk(cmd_valid == 1'b0, "R6 no record", 64'(cmd_valid), 0);
      if (n > 0 && h[63:32] < 40) exp_rf[h[37:32]] = pw[0];
      @(negedge clk);
      read_chk((h[63:32] < 64) ? int'(h[37:32]) : 0, "R6 regfile write");
    end else begin
      chk(cmd_valid == 1'b1, "R2 record valid", 64'(cmd_valid), 1);
      chk(cmd_opcode == op, "R2 opcode", 64'(cmd_opcode), 64'(op));
      chk(cmd_inline == h[63:32], "R2 inline", 64'(cmd_inline), h[63:32]);
      chk(cmd_nwords == 4'(n), "R2 nwords", 64'(cmd_nwords), 64'(n));
      for (int i = 0; i < n; i++)
        chk(cmd_payload[i*64 +: 64] == pw[i], "R2 payload slot", cmd_payload[i*64 +: 64], pw[i]);
      for (int k = $urandom % 3; k > 0; k--) begin
        @(negedge clk);
        chk(cmd_valid && cmd_opcode == op && cmd_inline == h[63:32], "R8 record held",
            64'(cmd_opcode), 64'(op));
        chk(word_ready == 1'b0, "R9 ready low during offer", 64'(word_ready), 0);
      end
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      chk(cmd_valid == 1'b0, "R8 record taken", 64'(cmd_valid), 0);
      for (int k = $urandom % 4; k > 0; k--) begin
        chk(word_ready == 1'b0, "R8 stall until done", 64'(word_ready), 0);
        @(negedge clk);
      end
      chk(word_ready == 1'b0, "R8 stall until done", 64'(word_ready), 0);
      cmd_done = 1'b1;
      @(negedge clk);
      cmd_done = 1'b0;
      chk(word_ready == 1'b1, "R8 resume after done", 64'(word_ready), 1);
    end
  endtask

  function automatic logic [63:0] rand_hdr();
    logic [31:0] r = $urandom;
    int n;
    case ($urandom % 8)
      0: begin
        logic [7:0] ops [6] = '{3, 4, 5, 6, 7, 9};
        n = $urandom % 9;
        return mk(ops[$urandom % 6], 14'(2 * n), r, 2'b11, 8'd0);
      end
      1: begin
        n = $urandom % 8;
        return mk(8'd8, 14'(2 * (n + 1)), {r[31:11], 3'(n), r[7:0]}, 2'b11, 8'd0);
      end
      2: return mk(8'd1, 14'(2 * ($urandom % 3)), r, 2'b11, 8'd0);
      3: return mk(8'd2, 14'(2 * ($urandom % 3)), 32'($urandom % 50), 2'b11, 8'd0);
      4: return mk(8'd3, 14'(2 * ($urandom % 4)), r, 2'($urandom % 3), 8'd0);
      5: return mk(8'd4, 14'(2 * ($urandom % 4)), r, 2'b11, 8'(1 + $urandom % 255));
      6: return mk(8'd5, 14'(2 * ($urandom % 5) + 1), r, 2'b11, 8'd0);
      default: begin
        n = $urandom % 4;
        case ($urandom % 3)
          0: return mk(8'(10 + $urandom % 240), 14'(2 * n), r, 2'b11, 8'd0);
          1: return mk(8'd6, 14'(2 * (9 + n)), r, 2'b11, 8'd0);
          default: return mk(8'd8, 14'(2 * n), {r[31:11], 3'(n + 2), r[7:0]}, 2'b11, 8'd0);
        endcase
      end
    endcase
  endfunction

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    for (int i = 0; i < 40; i++) exp_rf[i] = 64'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(word_ready == 1'b1 && cmd_valid == 1'b0, "R1 reset handshake", 64'({word_ready, cmd_valid}), 2);
    chk(err == 1'b0 && finish == 1'b0, "R1 reset pulses", 64'({err, finish}), 0);
    read_chk(7, "R1 regfile reset");
    // directed corners
    run_pkt(mk(8'd6, 14'd16, 32'h1234, 2'b11, 8'd0));     // R4 exactly 8 words ok
    run_pkt(mk(8'd6, 14'd18, 32'h1, 2'b11, 8'd0));        // R4 9 words
    run_pkt(mk(8'd0, 14'd0, 32'h0, 2'b11, 8'd0));         // R3 opcode 0
    run_pkt(mk(8'd10, 14'd2, 32'h0, 2'b11, 8'd0));        // R3 opcode 10
    run_pkt(mk(8'd1, 14'd0, 32'h0, 2'b11, 8'd0));         // R7 finish
    run_pkt(mk(8'd9, 14'd0, 32'h3, 2'b11, 8'd0));         // R2 zero payload
    run_pkt(mk(8'd8, 14'd16, 32'h0000_0701, 2'b11, 8'd0)); // R5 seven args
    run_pkt(mk(8'd8, 14'd4, 32'h0000_0001, 2'b11, 8'd0));  // R5 mismatch
    run_pkt(mk(8'd2, 14'd2, 32'd5, 2'b11, 8'd0));         // R6 write 5
    run_pkt(mk(8'd2, 14'd2, 32'd45, 2'b11, 8'd0));        // R6 dropped
    read_chk(5, "R6 no alias of dropped write");
    read_chk(45, "R6 out-of-range read zero");
    @(negedge clk);
    word = mk(8'd0, 14'd0, 0, 2'b11, 8'd0); word_valid = 1'b1;  // back-to-back errors
    @(negedge clk);
    chk(err == 1'b1, "R3 first err", 64'(err), 1);
    @(negedge clk);
    word_valid = 1'b0;
    chk(err == 1'b1, "R3 second err", 64'(err), 1);
    @(negedge clk);
    chk(err == 1'b0, "R3 err cleared", 64'(err), 0);
    for (int p = 0; p < 400; p++) run_pkt(rand_hdr());
    for (int i = 0; i < 64; i++) read_chk(i, "R6 final regfile sweep");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule